// File: doc/BRIEF.md
# Flash Programming Command Controller

This block is the command front end of an on-chip flash store. Software or an external programmer writes an operation code into a command register on a small byte-wide I/O register bus. The block decodes the code and checks it against the requester that issued it, either the external programmer or code running on the chip itself. It then runs the operation against a behavioural memory. That memory holds a code region of byte words and one lock byte.

Each accepted erase or write keeps a busy flag raised for a fixed, parameterised number of clock cycles. The memory effect is applied in the same cycle that the flag drops, so a poller that waits for the flag to clear always sees the finished result. Target address and data are taken from side inputs in the cycle the command is accepted. The memory can be read back at any time through a combinational read port.

Erased bytes read as all ones, and programming can only clear bits. The commands differ in reach. One erase wipes the code region together with the lock byte. Another erase wipes only the code region. A bulk write programs every code word and never touches the lock byte.

Top module: `nvm_cmd_ctrl`

## Requirements
- R1: After reset the status register (I/O offset 0x32) and the command register (offset 0x33) both read 0x00, and every code word and the lock byte read 0xFF.
- R2: An accepted erase or write raises bit 7 of the status register from the cycle after the command write, keeps it high for exactly OP_CYCLES cycles, and the memory shows the result when it falls.
- R3: The command register holds the operation code in bits 5:0 (the written byte's bits 7:6 are dropped) and bits 7:6 always read 0. Writes to the status register change nothing.
- R4: Code 0x10 sets every code word and the lock byte to 0xFF.
- R5: Code 0x11 replaces every code word with the old value ANDed with the data input, and leaves the lock byte unchanged.
- R6: Code 0x14 sets every code word to 0xFF and leaves the lock byte unchanged.
- R7: Code 0x1D replaces the addressed byte with the old value ANDed with the data input. Address CODE_WORDS selects the lock byte.
- R8: Code 0x18 sets to 0xFF every code word whose address shares the addressed word's page (address divided by PAGE_WORDS), and leaves all other bytes unchanged.
- R9: With req_self = 1, only codes 0x00, 0x1D and 0x18 are accepted. Any other code leaves busy low, the command register unchanged and the memory unchanged.
- R10: A code outside the six defined ones (0x00, 0x10, 0x11, 0x14, 0x18, 0x1D) is ignored, with the same effect as a rejected code.
- R11: A command written while busy is high is ignored: the command register and the memory are unaffected by it.
- R12: Code 0x00 is accepted: the command register reads 0x00 afterwards and busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_self | input | 1 | 1 = access issued by on-chip self-programming, 0 = external programmer |
| io_addr | input | 6 | I/O register offset |
| io_we | input | 1 | Register write strobe |
| io_wdata | input | 8 | Register write data |
| io_rdata | output | 8 | Register read data for io_addr (combinational) |
| nvm_addr | input | ADDR_W | Target byte address, sampled when a command is accepted |
| nvm_wdata | input | DATA_W | Program data, sampled when a command is accepted |
| mem_raddr | input | ADDR_W | Memory read address |
| mem_rdata | output | DATA_W | Memory read data (combinational, 0 above the lock byte) |

## Verification
The bench builds the block with CODE_WORDS = 16, PAGE_WORDS = 4 and OP_CYCLES = 5. With these values the whole array, including the lock byte at address 16, can be compared against a bench model after every operation. Four pages put page boundaries on both sides of an erased page. A five-cycle busy window is long enough to tell a correct duration from an off-by-one, and long enough to place a second command write inside it.

// File: rtl/nvm_cmd_pkg.sv
// Package: shared encodings for the flash command controller.
// Assumes an 8-bit I/O register bus with 6-bit offsets.
package nvm_cmd_pkg;

    localparam logic [5:0] CSR_OFS = 6'h32;
    localparam logic [5:0] CMD_OFS = 6'h33;

    typedef enum logic [5:0] {
        CMD_NOP        = 6'h00,
        CMD_CHIP_ERASE = 6'h10,
        CMD_CHIP_WRITE = 6'h11,
        CMD_SECT_ERASE = 6'h14,
        CMD_PAGE_ERASE = 6'h18,
        CMD_WORD_WRITE = 6'h1D
    } cmd_code_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ERASE_ALL,
        OP_WRITE_ALL,
        OP_ERASE_CODE,
        OP_WRITE_WORD,
        OP_ERASE_PAGE
    } op_kind_e;

endpackage

// File: rtl/nvm_cmd_decode.sv
// Module: nvm_cmd_decode
// Maps a 6-bit command code to an operation kind and says whether the
// requester may issue it. Purely combinational; assumes the caller
// qualifies the result with the write strobe and the busy state.
module nvm_cmd_decode
    import nvm_cmd_pkg::*;
(
    input  logic [5:0] code,
    input  logic       req_self,
    output logic       accept,
    output op_kind_e   op
);

    logic legal;
    logic self_ok;

    // Decode the code into an operation and mark legal codes.
    always_comb begin
        legal   = 1'b1;
        self_ok = 1'b0;
        op      = OP_NONE;
        unique case (code)
            CMD_NOP:        self_ok = 1'b1;
            CMD_CHIP_ERASE: op = OP_ERASE_ALL;
            CMD_CHIP_WRITE: op = OP_WRITE_ALL;
            CMD_SECT_ERASE: op = OP_ERASE_CODE;
            CMD_PAGE_ERASE: begin op = OP_ERASE_PAGE; self_ok = 1'b1; end
            CMD_WORD_WRITE: begin op = OP_WRITE_WORD; self_ok = 1'b1; end
            default:        legal = 1'b0;
        endcase
    end

    // Self-programming may only use the restricted subset.
    always_comb accept = legal && (self_ok || !req_self);

endmodule

// File: rtl/nvm_op_seq.sv
// Module: nvm_op_seq
// Holds one operation for OP_CYCLES cycles and pulses commit in the last
// one. Assumes start is only asserted while busy is low.
module nvm_op_seq
    import nvm_cmd_pkg::*;
#(
    parameter int OP_CYCLES = 4,
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  op_kind_e          op_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              busy,
    output logic              commit,
    output op_kind_e          op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    localparam int CNT_W = $clog2(OP_CYCLES) + 1;

    logic [CNT_W-1:0] cnt_q;

    // Commit happens in the final busy cycle.
    always_comb commit = busy && (cnt_q == '0);

    // Busy flag and remaining-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= CNT_W'(OP_CYCLES - 1);
        end else if (busy) begin
            if (cnt_q == '0) busy <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    // Latch the operation and its operands when it starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_NONE;
            addr_q <= '0;
            data_q <= '0;
        end else if (start) begin
            op_q   <= op_in;
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end

endmodule

// File: rtl/nvm_store.sv
// Module: nvm_store
// Behavioural flash array: CODE_WORDS code bytes plus one lock byte at
// address CODE_WORDS. Erased bytes are all ones; programming ANDs.
// Assumes CODE_WORDS and PAGE_WORDS are powers of two.
module nvm_store
    import nvm_cmd_pkg::*;
#(
    parameter int CODE_WORDS = 64,
    parameter int PAGE_WORDS = 8,
    parameter int ADDR_W     = 7,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  op_kind_e          op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int                CODE_AW   = $clog2(CODE_WORDS);
    localparam int                PAGE_SH   = $clog2(PAGE_WORDS);
    localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(CODE_WORDS);
    localparam logic [DATA_W-1:0] ERASED    = '1;

    logic [DATA_W-1:0] code_view [CODE_WORDS];
    logic [DATA_W-1:0] lock_q;

    for (genvar w = 0; w < CODE_WORDS; w++) begin : g_word
        localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(w);
        logic [DATA_W-1:0] word_q;

        // Update this code word on commit according to the operation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= ERASED;
            end else if (commit) begin
                case (op)
                    OP_ERASE_ALL, OP_ERASE_CODE: word_q <= ERASED;
                    OP_WRITE_ALL:                word_q <= word_q & data;
                    OP_WRITE_WORD:
                        if (addr == WADDR) word_q <= word_q & data;
                    OP_ERASE_PAGE:
                        if ((addr >> PAGE_SH) == (WADDR >> PAGE_SH)) word_q <= ERASED;
                    default: ;
                endcase
            end
        end

        assign code_view[w] = word_q;
    end

    // Lock byte: only the full erase or a word write to it touches it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= ERASED;
        end else if (commit) begin
            if (op == OP_ERASE_ALL)
                lock_q <= ERASED;
            else if (op == OP_WRITE_WORD && addr == LOCK_ADDR)
                lock_q <= lock_q & data;
        end
    end

    // Combinational read port.
    always_comb begin
        if (raddr == LOCK_ADDR)      rdata = lock_q;
        else if (raddr < LOCK_ADDR)  rdata = code_view[raddr[CODE_AW-1:0]];
        else                         rdata = '0;
    end

endmodule

// File: rtl/nvm_cmd_ctrl.sv
// Module: nvm_cmd_ctrl (top)
// Flash command controller: status register with busy flag at 0x32,
// command register at 0x33, requester-dependent command filtering,
// fixed-latency sequencing and a behavioural code/lock array.
// Assumes power-of-two CODE_WORDS and PAGE_WORDS, OP_CYCLES >= 1.
module nvm_cmd_ctrl
    import nvm_cmd_pkg::*;
#(
    parameter int CODE_WORDS = 64,
    parameter int PAGE_WORDS = 8,
    parameter int OP_CYCLES  = 4,
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = $clog2(CODE_WORDS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_self,
    input  logic [5:0]        io_addr,
    input  logic              io_we,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic [ADDR_W-1:0] nvm_addr,
    input  logic [DATA_W-1:0] nvm_wdata,
    input  logic [ADDR_W-1:0] mem_raddr,
    output logic [DATA_W-1:0] mem_rdata
);

    logic              accept;
    op_kind_e          dec_op;
    logic              cmd_wr;
    logic              take;
    logic              start;
    logic [5:0]        cmd_q;
    logic              busy;
    logic              commit;
    op_kind_e          run_op;
    logic [ADDR_W-1:0] run_addr;
    logic [DATA_W-1:0] run_data;

    nvm_cmd_decode u_dec (
        .code     (io_wdata[5:0]),
        .req_self (req_self),
        .accept   (accept),
        .op       (dec_op)
    );

    // Qualify a command write: register hit, idle, and permitted.
    always_comb begin
        cmd_wr = io_we && (io_addr == CMD_OFS);
        take   = cmd_wr && !busy && accept;
        start  = take && (dec_op != OP_NONE);
    end

    // Command register keeps the last accepted code.
    always_ff @(posedge clk) begin
        if (!rst_n)    cmd_q <= '0;
        else if (take) cmd_q <= io_wdata[5:0];
    end

    nvm_op_seq #(
        .OP_CYCLES (OP_CYCLES),
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .op_in   (dec_op),
        .addr_in (nvm_addr),
        .data_in (nvm_wdata),
        .busy    (busy),
        .commit  (commit),
        .op_q    (run_op),
        .addr_q  (run_addr),
        .data_q  (run_data)
    );

    nvm_store #(
        .CODE_WORDS (CODE_WORDS),
        .PAGE_WORDS (PAGE_WORDS),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W)
    ) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .op     (run_op),
        .addr   (run_addr),
        .data   (run_data),
        .raddr  (mem_raddr),
        .rdata  (mem_rdata)
    );

    // Register read mux.
    always_comb begin
        case (io_addr)
            CSR_OFS: io_rdata = {busy, 7'b0};
            CMD_OFS: io_rdata = {2'b00, cmd_q};
            default: io_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/nvm_cmd_ctrl_chk.sv
// Module: nvm_cmd_ctrl_chk
// Protocol checks for nvm_cmd_ctrl, bound to every instance of it.
// Assumes the bound instance exposes busy and cmd_q.
module nvm_cmd_ctrl_chk #(
    parameter int OP_CYCLES = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_self,
    input logic [5:0] io_addr,
    input logic       io_we,
    input logic [7:0] io_wdata,
    input logic [7:0] io_rdata,
    input logic       busy,
    input logic [5:0] cmd_q
);

    logic        wr_cmd;
    logic        is_op;
    logic        is_legal;
    logic        self_ok;
    logic [15:0] run_len;

    // Port-level view of a command write and its permission.
    always_comb begin
        wr_cmd   = io_we && (io_addr == 6'h33);
        is_op    = io_wdata[5:0] inside {6'h10, 6'h11, 6'h14, 6'h18, 6'h1D};
        is_legal = is_op || (io_wdata[5:0] == 6'h00);
        self_ok  = io_wdata[5:0] inside {6'h00, 6'h18, 6'h1D};
    end

    // Length of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 16'd1;
        else           run_len <= '0;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!busy && cmd_q == 6'h00)); // R1
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !busy && is_op && (!req_self || self_ok)) |=> busy); // R2
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < 16'(OP_CYCLES))); // R2
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == 16'(OP_CYCLES))); // R2
    AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == 6'h33) |-> (io_rdata[7:6] == 2'b00)); // R3
    AST_REJECT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !busy && !(is_legal && (!req_self || self_ok))) |=> (!busy && $stable(cmd_q))); // R9
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && busy) |=> $stable(cmd_q)); // R11
    AST_NOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !busy && io_wdata[5:0] == 6'h00) |=> (!busy && cmd_q == 6'h00)); // R12

endmodule

bind nvm_cmd_ctrl nvm_cmd_ctrl_chk #(.OP_CYCLES(OP_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_self (req_self),
    .io_addr  (io_addr),
    .io_we    (io_we),
    .io_wdata (io_wdata),
    .io_rdata (io_rdata),
    .busy     (busy),
    .cmd_q    (cmd_q)
);

// File: tb/sim_nvm_cmd_ctrl.sv
// Directed bench for nvm_cmd_ctrl with a reference model of the array.
module sim_nvm_cmd_ctrl;

    localparam int CW   = 16;
    localparam int PW   = 4;
    localparam int OPC  = 5;
    localparam int AW   = $clog2(CW) + 1;
    localparam int LOCK = CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_self = 1'b0;
    logic [5:0]    io_addr = 6'h00;
    logic          io_we = 1'b0;
    logic [7:0]    io_wdata = 8'h00;
    logic [7:0]    io_rdata;
    logic [AW-1:0] nvm_addr = '0;
    logic [7:0]    nvm_wdata = 8'h00;
    logic [AW-1:0] mem_raddr = '0;
    logic [7:0]    mem_rdata;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    logic [7:0] model [0:LOCK];

    always #5 clk = ~clk;

    nvm_cmd_ctrl #(.CODE_WORDS(CW), .PAGE_WORDS(PW), .OP_CYCLES(OPC)) u0 (
        .clk(clk), .rst_n(rst_n), .req_self(req_self),
        .io_addr(io_addr), .io_we(io_we), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .nvm_addr(nvm_addr), .nvm_wdata(nvm_wdata),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic rd_reg(input logic [5:0] a, output logic [7:0] v);
        io_addr = a;
        #1 v = io_rdata;
    endtask

    // Reference model of each operation's effect.
    task automatic apply(input logic [5:0] code, input int a, input logic [7:0] d);
        case (code)
            6'h10: for (int i = 0; i <= LOCK; i++) model[i] = 8'hFF;
            6'h11: for (int i = 0; i < CW; i++) model[i] = model[i] & d;
            6'h14: for (int i = 0; i < CW; i++) model[i] = 8'hFF;
            6'h1D: if (a <= LOCK) model[a] = model[a] & d;
            6'h18: for (int i = 0; i < CW; i++) if (i / PW == a / PW) model[i] = 8'hFF;
            default: ;
        endcase
    endtask

    task automatic check_mem(input string req);
        for (int i = 0; i <= LOCK; i++) begin
            mem_raddr = AW'(i);
            #1 chk(mem_rdata == model[i], req, $sformatf("mem[%0d]", i), mem_rdata, model[i]);
        end
    endtask

    // Issue one command byte; check busy window and command register.
    task automatic issue(input logic [7:0] raw, input int a, input logic [7:0] d,
                         input bit self, input bit exp_start, input string req);
        logic [7:0] prev, v;
        int n;
        @(negedge clk);
        rd_reg(6'h33, prev);
        req_self = self; nvm_addr = AW'(a); nvm_wdata = d;
        io_addr = 6'h33; io_wdata = raw; io_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        io_we = 1'b0;
        rd_reg(6'h32, v);
        if (exp_start) begin
            n = 0;
            while (v[7] && n < 100) begin
                n++;
                @(negedge clk);
                rd_reg(6'h32, v);
            end
            chk(n == OPC, "R2", "busy cycles", n, OPC);
            apply(raw[5:0], a, d);
        end else begin
            chk(v == 8'h00, req, "busy after ignored cmd", v, 0);
        end
        rd_reg(6'h33, v);
        if (exp_start || (raw[5:0] == 6'h00 && !(!self && 0)))
            chk(v == {2'b00, (exp_start || raw[5:0] == 6'h00) ? raw[5:0] : prev[5:0]}, req, "cmd reg", v, {2'b00, raw[5:0]});
        else
            chk(v == prev, req, "cmd reg unchanged", v, prev);
        req_self = 1'b0;
        check_mem(req);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd_reg(6'h32, v); chk(v == 8'h00, "R1", "status reset", v, 0);
        rd_reg(6'h33, v); chk(v == 8'h00, "R1", "command reset", v, 0);
        check_mem("R1");
    endtask

    task automatic t_word_write;
        issue(8'h1D, 3, 8'hA5, 1'b0, 1'b1, "R7");
        issue(8'h1D, 3, 8'h0F, 1'b0, 1'b1, "R7");
        issue(8'h1D, LOCK, 8'hFC, 1'b0, 1'b1, "R7");
        issue(8'h1D, CW - 1, 8'h3C, 1'b0, 1'b1, "R7");
    endtask

    task automatic t_fields;
        logic [7:0] v;
        @(negedge clk);
        io_addr = 6'h32; io_wdata = 8'hFF; io_we = 1'b1;
        @(negedge clk);
        io_we = 1'b0;
        rd_reg(6'h32, v); chk(v == 8'h00, "R3", "status write ignored", v, 0);
        issue(8'hDD, 6, 8'h77, 1'b0, 1'b1, "R3");
    endtask

    task automatic t_page_erase;
        for (int i = 3; i <= 8; i++) issue(8'h1D, i, 8'h12, 1'b0, 1'b1, "R8");
        issue(8'h18, 5, 8'h00, 1'b0, 1'b1, "R8");
    endtask

    task automatic t_busy_ignore;
        logic [7:0] v;
        int n;
        @(negedge clk);
        nvm_addr = AW'(0); nvm_wdata = 8'h7F;
        io_addr = 6'h33; io_wdata = 8'h1D; io_we = 1'b1;
        @(negedge clk);
        io_wdata = 8'h10; nvm_wdata = 8'h00;
        @(negedge clk);
        io_we = 1'b0;
        rd_reg(6'h33, v); chk(v == 8'h1D, "R11", "cmd during busy", v, 8'h1D);
        n = 0;
        rd_reg(6'h32, v);
        while (v[7] && n < 100) begin n++; @(negedge clk); rd_reg(6'h32, v); end
        apply(6'h1D, 0, 8'h7F);
        check_mem("R11");
    endtask

    task automatic t_self;
        issue(8'h10, 0, 8'h00, 1'b1, 1'b0, "R9");
        issue(8'h11, 0, 8'h00, 1'b1, 1'b0, "R9");
        issue(8'h14, 0, 8'h00, 1'b1, 1'b0, "R9");
        issue(8'h1D, 9, 8'h5A, 1'b1, 1'b1, "R9");
        issue(8'h18, 13, 8'h00, 1'b1, 1'b1, "R9");
    endtask

    task automatic t_unknown;
        issue(8'h3F, 0, 8'h00, 1'b0, 1'b0, "R10");
        issue(8'h12, 0, 8'h00, 1'b0, 1'b0, "R10");
        issue(8'h1C, 2, 8'h00, 1'b0, 1'b0, "R10");
    endtask

    task automatic t_nop;
        issue(8'h00, 0, 8'h00, 1'b0, 1'b0, "R12");
        issue(8'h1D, 1, 8'hEE, 1'b0, 1'b1, "R12");
        issue(8'h00, 0, 8'h00, 1'b1, 1'b0, "R12");
    endtask

    initial begin
        for (int i = 0; i <= LOCK; i++) model[i] = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_word_write();
        t_fields();
        t_page_erase();
        t_busy_ignore();
        t_self();
        t_unknown();
        t_nop();
        issue(8'h11, 0, 8'hF0, 1'b0, 1'b1, "R5");
        issue(8'h14, 0, 8'h00, 1'b0, 1'b1, "R6");
        issue(8'h1D, 2, 8'h81, 1'b0, 1'b1, "R4");
        issue(8'h10, 0, 8'h00, 1'b0, 1'b1, "R4");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule